// File: doc/BRIEF.md
# Reset-Aware Memory Chip-Enable Gate

This block sits between a processor's active-low chip-enable request and a memory's chip-enable pin. While the system runs normally, the request passes straight through on a purely combinational path, so memory accesses gain no latency. While the system is held in reset, no new access may begin. An access that was already under way when reset arrived keeps its enable for a bounded grace window so that it can finish cleanly.

The grace window closes after a fixed number of clock cycles or as soon as the processor withdraws its request, whichever happens first. Once the window has closed, the memory stays deselected until the system leaves reset. A battery-backup flag overrides everything else and holds the memory deselected. The conditions that come from power sensing (system reset state, battery-backup mode) reach the block as synchronous digital flags.

Top module: `reset_ce_gate`

## Requirements
- R1: `ce_mem_no` is low only when `ce_req_ni` is low and `bkup_i` is low, and either `sys_rst_ni` is high or a grace window is open.
- R2: With `sys_rst_ni` high and `bkup_i` low, `ce_mem_no` equals `ce_req_ni` in the same cycle, with no clock edge in between.
- R3: If `ce_req_ni` is low in the first cycle with `sys_rst_ni` low, after a cycle with `sys_rst_ni` high, and stays low, then `ce_mem_no` is low for exactly GRACE_CYC = CLK_FREQ_MHZ * GRACE_US cycles, counting that first cycle. It is high from the next cycle on (1875 cycles with the defaults).
- R4: A grace window ends in the first cycle that `ce_req_ni` is high. After any grace window has ended, `ce_mem_no` stays high for as long as `sys_rst_ni` stays low, even if `ce_req_ni` goes low again.
- R5: If `ce_req_ni` is high in the cycle where `sys_rst_ni` falls, or first goes low while `sys_rst_ni` is already low, then `ce_mem_no` stays high.
- R6: While `bkup_i` is high, `ce_mem_no` is high, whatever the other inputs are.
- R7: While `rst_ni` is low, and right after it is released, the block treats the system as already in reset. A request that is low at power-up, while `sys_rst_ni` is low, gets no grace window.
- R8: In the first cycle that `sys_rst_ni` is high again, `ce_mem_no` once more follows `ce_req_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on clear, active low |
| ce_req_ni | input | 1 | Chip-enable request from the processor, active low |
| sys_rst_ni | input | 1 | System reset state, active low (low = in reset) |
| bkup_i | input | 1 | Battery-backup mode flag, active high |
| ce_mem_no | output | 1 | Chip-enable to the memory, active low |

## Verification
A corrupt grace counter shows at the memory pin as a window that is too long or too short. The bench catches this in the cycle the window should have closed, because it counts every low cycle of a full window against GRACE_CYC. A stale sample of the reset state shows up in the first reset cycle: either a grace window that should not exist or a missing low at the moment reset falls. A grace flag that wrongly re-arms shows within one cycle of the request going low again during reset.

// File: rtl/ceg_pkg.sv
package ceg_pkg;
  function automatic int unsigned grace_cycles(input int unsigned clk_mhz,
                                               input int unsigned win_us);
    return clk_mhz * win_us;
  endfunction
endpackage

// File: rtl/ceg_rst_track.sv
module ceg_rst_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_ni,
  output logic rst_edge_o
);
  logic run_q;

  // power-on clear assumes the system starts in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= sys_rst_ni;
  end

  assign rst_edge_o = run_q & ~sys_rst_ni;
endmodule

// File: rtl/ceg_grace_tmr.sv
module ceg_grace_tmr #(
  parameter int unsigned LIMIT = 1875,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic open_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             open_q;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (run_i) begin
      cnt_q  <= cnt_inc;
      open_q <= (cnt_inc < LIMIT[CNT_W-1:0]);
    end else begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end
  end

  assign open_o = open_q;

  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT[CNT_W-1:0]); // R3
  AST_OPEN_CLOSES_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !open_o); // R4
endmodule

// File: rtl/reset_ce_gate.sv
module reset_ce_gate
  import ceg_pkg::*;
#(
  parameter int unsigned CLK_FREQ_MHZ = 125,
  parameter int unsigned GRACE_US     = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_req_ni,
  input  logic sys_rst_ni,
  input  logic bkup_i,
  output logic ce_mem_no
);
  localparam int unsigned GRACE_CYC = grace_cycles(CLK_FREQ_MHZ, GRACE_US);
  localparam int unsigned CNT_W     = $clog2(GRACE_CYC + 1);

  logic in_rst;
  logic rst_edge;
  logic grace_open;
  logic hold;

  assign in_rst = ~sys_rst_ni;

  ceg_rst_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_rst_ni (sys_rst_ni),
    .rst_edge_o (rst_edge)
  );

  // in-flight access keeps its enable while the window is open
  assign hold = in_rst & ~ce_req_ni & (rst_edge | grace_open);

  ceg_grace_tmr #(
    .LIMIT (GRACE_CYC),
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (hold),
    .open_o (grace_open)
  );

  assign ce_mem_no = bkup_i | ce_req_ni | (in_rst & ~hold);

  AST_OUT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_mem_no |-> !ce_req_ni); // R1
  AST_BKUP_FORCES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkup_i |-> ce_mem_no); // R6
  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_rst & ce_mem_no & ~bkup_i) && in_rst) |-> ce_mem_no); // R4
  AST_NO_LATE_GRACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_rst & ce_req_ni) && in_rst) |-> ce_mem_no); // R5
endmodule

// File: tb/reset_ce_gate_tb_top.sv
module reset_ce_gate_tb_top;
  localparam int unsigned GRACE_CYC = 125 * 15;

  logic clk = 1'b0;
  logic rst_n;
  logic req_n;
  logic sys_n;
  logic bkup;
  logic ce_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  reset_ce_gate dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ce_req_ni  (req_n),
    .sys_rst_ni (sys_n),
    .bkup_i     (bkup),
    .ce_mem_no  (ce_n)
  );

  // {sys_n, bkup, req_n, expected ce_n}; each row lasts one cycle
  localparam logic [3:0] VEC [9] = '{
    4'b1_0_0_0,  // R2 pass low
    4'b1_0_1_1,  // R2 pass high
    4'b1_1_0_1,  // R6
    4'b1_1_1_1,  // R6
    4'b0_0_1_1,  // R5 reset falls with request high
    4'b0_0_0_1,  // R5 request low after reset fell
    4'b0_1_0_1,  // R6
    4'b1_0_0_0,  // R8
    4'b1_0_1_1   // R2
  };

  task automatic chk(input string req, input logic exp);
    n_run++;
    if (ce_n !== exp) begin
      n_fail++;
      $display("FAIL %s: ce_mem_no=%b expected=%b at %0t", req, ce_n, exp, $time);
    end
  endtask

  task automatic drive(input logic s, input logic b, input logic r);
    @(negedge clk);
    sys_n = s; bkup = b; req_n = r;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog: expired, expected completion");
    finish_run();
  end

  initial begin
    int lows;
    rst_n = 1'b0; sys_n = 1'b1; req_n = 1'b1; bkup = 1'b0;
    #1;
    chk("R7 reset state", 1'b1);
    // power-up with system in reset and request low: no grace
    sys_n = 1'b0; req_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R7 held in clear", 1'b1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk("R7 after release", 1'b1);
    end

    drive(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 9; i++) begin
      drive(VEC[i][3], VEC[i][2], VEC[i][1]);
      chk($sformatf("vector %0d", i), VEC[i][0]);
    end

    // R3 full grace window
    drive(1'b1, 1'b0, 1'b0);
    chk("R2 before window", 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    lows = (ce_n === 1'b0) ? 1 : 0;
    for (int i = 1; i < GRACE_CYC; i++) begin
      @(negedge clk); #1;
      if (ce_n === 1'b0) lows++;
    end
    n_run++;
    if (lows != GRACE_CYC) begin
      n_fail++;
      $display("FAIL R3: low cycles=%0d expected=%0d", lows, GRACE_CYC);
    end
    @(negedge clk); #1;
    chk("R3 window closed", 1'b1);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    chk("R4 no rearm after full window", 1'b1);
    drive(1'b1, 1'b0, 1'b0);
    chk("R8 follows after reset", 1'b0);

    // R4 early end by withdrawn request
    drive(1'b0, 1'b0, 1'b0);
    chk("R3 first reset cycle low", 1'b0);
    repeat (10) begin
      @(negedge clk); #1;
    end
    chk("R3 window still open", 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    chk("R4 withdraw", 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    chk("R4 no rearm after withdraw", 1'b1);
    repeat (5) begin
      @(negedge clk); #1;
    end
    chk("R4 still high", 1'b1);

    // R6 backup during open window, R1 request must be low
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    chk("R6 backup in window", 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    chk("R1 window alive under backup", 1'b0);
    drive(1'b1, 1'b0, 1'b1);
    chk("R1 request high", 1'b1);

    finish_run();
  end
endmodule